// File: doc/BRIEF.md
# Parallel ATA Device Task File Register Block

This block is the register file that a parallel ATA target presents to the host. Two active-low block selects and a 3-bit register address pick either a command-block register or a control-block register. Several addresses are split: a read returns one register and a write lands in another. The block holds the transfer parameters (sector count, sector number, cylinder bytes, device/head byte) and shows them to the back end as one 28-bit logical block address. It also holds the feature byte. A write of a command code produces a one-cycle issue pulse with that code and sets the busy state. Busy lasts until the back end reports completion.

The block keeps the busy, ready and error status, the error byte, and a pending-interrupt flag. From the pending flag, the interrupt-disable bit and the device-selection match it derives the active-high interrupt request. A soft-reset bit in the device-control register clears the parameter state and holds busy until software releases it. Word-wide data-port accesses are only decoded here. The data itself is moved by an outside buffer, so the block only passes the 16-bit read word through and raises the read and write strobes. Host strobes arrive as single-cycle pulses that are already synchronous to `clk`.

Top module: `pata_tf_regs`

## Requirements
- R1: With the command-block select low and the control-block select high, a write stores the low data byte as follows: address 2 holds the sector count, 3 the sector number, 4 cylinder low, 5 cylinder high and 6 the device/head byte. A read returns the stored byte in bits 7:0 with bits 15:8 zero. `lba_o` equals {device/head[3:0], cylinder high, cylinder low, sector number}.
- R2: At address 1, a read returns the error byte and a write loads the feature byte, which appears on `feature_o`. At address 7, a read returns the status byte and a write is a command.
- R3: With only the control-block select low, address 6 reads the alternate status (the same byte as status) and a write there loads device control (bit 1 interrupt disable, bit 2 soft reset). Address 7 reads the device-address byte {1,1,~head[3:0],~dev,dev}, where dev is device/head bit 4. A write to control-block address 7, a write with both selects low or a write with both selects high changes nothing. A read in the last two cases returns 0.
- R4: Address 0 in the command block is the data port. A read returns the 16-bit `dport_rdata_i`, and `dport_rd_o` / `dport_wr_o` are high in the cycle in which the strobe is presented.
- R5: A command write accepted while not busy pulses `cmd_stb_o` for exactly one cycle, in the cycle after the write edge, with `cmd_code_o` equal to the written byte. Status then reads 80h (bit 7 busy set, bit 6 ready clear).
- R6: A command write is ignored when device/head bit 4 differs from `own_dev_i`.
- R7: While busy, writes to command-block addresses 1 to 7 are ignored, but device-control writes are still accepted.
- R8: `done_i` while a command is busy clears busy, sets ready and marks an interrupt pending. With `done_err_i` high, status bit 0 is set and the error byte takes `done_code_i`. Without it, the error byte is 0 and status reads 40h. Accepting a new command clears status bit 0 and the error byte.
- R9: `irq_o` is high only when an interrupt is pending, interrupt disable is clear and device/head bit 4 equals `own_dev_i`. A status read (command-block address 7) clears the pending interrupt, and an alternate-status read does not.
- R10: Setting interrupt disable forces `irq_o` low from the next cycle while keeping the pending state. Clearing it brings the request back.
- R11: While soft reset is set, `srst_o` is high, the parameter registers, the error byte and the pending interrupt are zero, status reads 80h, and commands are ignored. Clearing the bit returns status to 40h.
- R12: After reset, `rdata_o`, all parameter outputs, `irq_o` and `cmd_stb_o` are 0, and status reads 40h.
- R13: `rdata_o` is registered. It takes the addressed value at the edge that samples `rd_i` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_blk_sel_n | input | 1 | Command-block select, active low |
| ctl_blk_sel_n | input | 1 | Control-block select, active low |
| reg_addr_i | input | 3 | Register address |
| rd_i | input | 1 | Single-cycle host read strobe |
| wr_i | input | 1 | Single-cycle host write strobe |
| wdata_i | input | 8 | Host register write byte |
| rdata_o | output | 16 | Registered read data |
| dport_rdata_i | input | 16 | Word from the data-port buffer |
| dport_rd_o | output | 1 | Data-port read strobe |
| dport_wr_o | output | 1 | Data-port write strobe |
| own_dev_i | input | 1 | This device's number (0 or 1) |
| done_i | input | 1 | Command finished pulse from the back end |
| done_err_i | input | 1 | Finished command ended in error |
| done_code_i | input | 8 | Error byte reported with completion |
| cmd_stb_o | output | 1 | Command issued pulse |
| cmd_code_o | output | 8 | Last accepted command code |
| feature_o | output | 8 | Feature byte |
| sect_cnt_o | output | 8 | Sector count |
| lba_o | output | 28 | Assembled block address |
| dev_head_o | output | 8 | Device/head byte |
| srst_o | output | 1 | Soft reset active |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check these properties:
- The issue pulse lasts one cycle.
- A command write while busy leaves the code and the pulse untouched.
- Completion clears busy and raises the pending flag.
- A status read drops the pending flag.
- Setting interrupt disable silences the request.
- Soft reset empties the parameter bank and the error state.
- Writes with both selects low leave the parameters alone.

Only the bench scenarios can show several things:
- The read/write split at shared addresses.
- The device-address byte.
- The difference between a status read and an alternate-status read.
- The interrupt coming back when disable or selection is restored.
- Error reporting followed by its clearing on the next command.

// File: rtl/pata_tf_pkg.sv
// Shared constants and types for the task file register block.
// Assumes the register address bus is 3 bits and register bytes are 8 bits.
package pata_tf_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int N_PARAM = 6;

    // Decoded register slot for one host access
    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_ERRFEAT, SEL_SCNT, SEL_SNUM, SEL_CYLL,
        SEL_CYLH, SEL_DEVHEAD, SEL_STATCMD, SEL_ALTCTL, SEL_DEVADDR
    } tf_sel_e;

    // Index of each byte inside the parameter bank
    localparam int PI_FEAT    = 0;
    localparam int PI_SCNT    = 1;
    localparam int PI_SNUM    = 2;
    localparam int PI_CYLL    = 3;
    localparam int PI_CYLH    = 4;
    localparam int PI_DEVHEAD = 5;

    // Status byte bit positions
    localparam int ST_BSY = 7;
    localparam int ST_RDY = 6;
    localparam int ST_ERR = 0;

    // Device control bit positions
    localparam int DC_NIEN = 1;
    localparam int DC_SRST = 2;

    // Device/head byte: device select bit
    localparam int DH_DEV = 4;
endpackage

// File: rtl/pata_tf_decode.sv
// Address decoder: maps the two active-low block selects and the register
// address to one register slot. Assumes at most one access per cycle.
// Both selects low or both high selects nothing.
module pata_tf_decode
    import pata_tf_pkg::*;
(
    input  logic              cmd_blk_sel_n,
    input  logic              ctl_blk_sel_n,
    input  logic [ADDR_W-1:0] addr_i,
    output tf_sel_e           sel_o
);
    // Pick the register slot for the current address
    always_comb begin
        sel_o = SEL_NONE;
        if (!cmd_blk_sel_n && ctl_blk_sel_n) begin
            case (addr_i)
                3'd0: sel_o = SEL_DATA;
                3'd1: sel_o = SEL_ERRFEAT;
                3'd2: sel_o = SEL_SCNT;
                3'd3: sel_o = SEL_SNUM;
                3'd4: sel_o = SEL_CYLL;
                3'd5: sel_o = SEL_CYLH;
                3'd6: sel_o = SEL_DEVHEAD;
                3'd7: sel_o = SEL_STATCMD;
            endcase
        end else if (cmd_blk_sel_n && !ctl_blk_sel_n) begin
            if (addr_i == 3'd6)
                sel_o = SEL_ALTCTL;
            else if (addr_i == 3'd7)
                sel_o = SEL_DEVADDR;
        end
    end
endmodule

// File: rtl/pata_tf_param_bank.sv
// Parameter bank: N byte registers, each written by its own enable.
// A clear input (soft reset) empties all of them. Assumes enables are one-hot or idle.
module pata_tf_param_bank #(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [N-1:0]        wr_en_i,
    input  logic [W-1:0]        wdata_i,
    output logic [N-1:0][W-1:0] regs_o
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        // Hold one parameter byte
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)
                q <= '0;
            else if (wr_en_i[g])
                q <= wdata_i;
        end
        assign regs_o[g] = q;
    end

    // R1
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_i));
    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (regs_o == '0));
endmodule

// File: rtl/pata_tf_cmd_ctrl.sv
// Command and status control: device control bits, command issue, busy,
// completion, error byte and the pending interrupt. Assumes done_i is a
// single-cycle pulse. The caller has already gated cmd_wr_i with device selection.
module pata_tf_cmd_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wr_i,
    input  logic         ctl_wr_i,
    input  logic [1:0]   ctl_bits_i,
    input  logic [W-1:0] wdata_i,
    input  logic         stat_rd_i,
    input  logic         done_i,
    input  logic         done_err_i,
    input  logic [W-1:0] done_code_i,
    output logic         busy_o,
    output logic         pend_o,
    output logic         err_flag_o,
    output logic [W-1:0] err_reg_o,
    output logic         nien_o,
    output logic         srst_o,
    output logic         cmd_stb_o,
    output logic [W-1:0] cmd_code_o
);
    logic busy_cmd;
    logic accept;
    logic finish;

    assign busy_o = busy_cmd | srst_o;
    assign accept = cmd_wr_i & ~busy_o;
    assign finish = done_i & busy_cmd & ~srst_o;

    // Device control: soft reset and interrupt disable
    always_ff @(posedge clk) begin
        if (!rst_n)
            {srst_o, nien_o} <= 2'b00;
        else if (ctl_wr_i)
            {srst_o, nien_o} <= ctl_bits_i;
    end

    // Command issue pulse, code latch and busy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cmd   <= 1'b0;
            cmd_stb_o  <= 1'b0;
            cmd_code_o <= '0;
        end else begin
            cmd_stb_o <= accept;
            if (accept)
                cmd_code_o <= wdata_i;
            if (srst_o)
                busy_cmd <= 1'b0;
            else if (accept)
                busy_cmd <= 1'b1;
            else if (finish)
                busy_cmd <= 1'b0;
        end
    end

    // Completion: error state and pending interrupt
    always_ff @(posedge clk) begin
        if (!rst_n || srst_o) begin
            pend_o     <= 1'b0;
            err_flag_o <= 1'b0;
            err_reg_o  <= '0;
        end else if (accept) begin
            pend_o     <= 1'b0;
            err_flag_o <= 1'b0;
            err_reg_o  <= '0;
        end else begin
            if (stat_rd_i)
                pend_o <= 1'b0;
            if (finish) begin
                pend_o     <= 1'b1;
                err_flag_o <= done_err_i;
                err_reg_o  <= done_err_i ? done_code_i : '0;
            end
        end
    end

    // R5
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o);
    // R5
    cmd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !busy_o && !ctl_wr_i) |=> (cmd_stb_o && busy_o));
    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && busy_o) |=> (!cmd_stb_o && $stable(cmd_code_o)));
    // R8
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && busy_cmd && !srst_o && !ctl_wr_i) |=> (!busy_o && pend_o));
    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !(done_i && busy_cmd)) |=> !pend_o);
    // R11
    srst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> (!pend_o && !err_flag_o && err_reg_o == '0));
endmodule

// File: rtl/pata_tf_regs.sv
// Task file register block top: decodes host accesses, routes writes to the
// parameter bank and command control, muxes registered read data and derives
// the interrupt request. Assumes rd_i and wr_i are single-cycle, never
// together, and already synchronous to clk.
module pata_tf_regs
    import pata_tf_pkg::*;
#(
    parameter int DPORT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_blk_sel_n,
    input  logic               ctl_blk_sel_n,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [DPORT_W-1:0] rdata_o,
    input  logic [DPORT_W-1:0] dport_rdata_i,
    output logic               dport_rd_o,
    output logic               dport_wr_o,
    input  logic               own_dev_i,
    input  logic               done_i,
    input  logic               done_err_i,
    input  logic [REG_W-1:0]   done_code_i,
    output logic               cmd_stb_o,
    output logic [REG_W-1:0]   cmd_code_o,
    output logic [REG_W-1:0]   feature_o,
    output logic [REG_W-1:0]   sect_cnt_o,
    output logic [4*REG_W-5:0] lba_o,
    output logic [REG_W-1:0]   dev_head_o,
    output logic               srst_o,
    output logic               irq_o
);
    localparam int PAD_W = DPORT_W - REG_W;

    tf_sel_e                        sel;
    logic [N_PARAM-1:0]             wr_en;
    logic [N_PARAM-1:0][REG_W-1:0]  param_q;
    logic                           busy, pend, err_flag, nien;
    logic [REG_W-1:0]               err_reg;
    logic                           tf_wr_ok, cmd_wr, ctl_wr, stat_rd, dev_match;
    logic [REG_W-1:0]               status_b, devaddr_b, reg_b;
    logic [DPORT_W-1:0]             rd_next;

    pata_tf_decode u_decode (
        .cmd_blk_sel_n (cmd_blk_sel_n),
        .ctl_blk_sel_n (ctl_blk_sel_n),
        .addr_i        (reg_addr_i),
        .sel_o         (sel)
    );

    assign dev_match = (param_q[PI_DEVHEAD][DH_DEV] == own_dev_i);
    assign tf_wr_ok  = wr_i & ~busy;
    assign cmd_wr    = wr_i & (sel == SEL_STATCMD) & dev_match;
    assign ctl_wr    = wr_i & (sel == SEL_ALTCTL);
    assign stat_rd   = rd_i & (sel == SEL_STATCMD);
    assign dport_rd_o = rd_i & (sel == SEL_DATA);
    assign dport_wr_o = wr_i & (sel == SEL_DATA);

    // Route an accepted task file write to its parameter byte
    always_comb begin
        wr_en = '0;
        if (tf_wr_ok) begin
            case (sel)
                SEL_ERRFEAT: wr_en[PI_FEAT]    = 1'b1;
                SEL_SCNT:    wr_en[PI_SCNT]    = 1'b1;
                SEL_SNUM:    wr_en[PI_SNUM]    = 1'b1;
                SEL_CYLL:    wr_en[PI_CYLL]    = 1'b1;
                SEL_CYLH:    wr_en[PI_CYLH]    = 1'b1;
                SEL_DEVHEAD: wr_en[PI_DEVHEAD] = 1'b1;
                default:     wr_en = '0;
            endcase
        end
    end

    pata_tf_param_bank #(.N(N_PARAM), .W(REG_W)) u_params (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (srst_o),
        .wr_en_i (wr_en),
        .wdata_i (wdata_i),
        .regs_o  (param_q)
    );

    pata_tf_cmd_ctrl #(.W(REG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr),
        .ctl_wr_i    (ctl_wr),
        .ctl_bits_i  (wdata_i[DC_SRST:DC_NIEN]),
        .wdata_i     (wdata_i),
        .stat_rd_i   (stat_rd),
        .done_i      (done_i),
        .done_err_i  (done_err_i),
        .done_code_i (done_code_i),
        .busy_o      (busy),
        .pend_o      (pend),
        .err_flag_o  (err_flag),
        .err_reg_o   (err_reg),
        .nien_o      (nien),
        .srst_o      (srst_o),
        .cmd_stb_o   (cmd_stb_o),
        .cmd_code_o  (cmd_code_o)
    );

    // Assemble the status and device-address bytes
    always_comb begin
        status_b         = '0;
        status_b[ST_BSY] = busy;
        status_b[ST_RDY] = ~busy;
        status_b[ST_ERR] = err_flag;
        devaddr_b = {2'b11, ~param_q[PI_DEVHEAD][3:0],
                     ~param_q[PI_DEVHEAD][DH_DEV], param_q[PI_DEVHEAD][DH_DEV]};
    end

    // Pick the byte or word a read returns
    always_comb begin
        reg_b   = '0;
        rd_next = '0;
        case (sel)
            SEL_ERRFEAT: reg_b = err_reg;
            SEL_SCNT:    reg_b = param_q[PI_SCNT];
            SEL_SNUM:    reg_b = param_q[PI_SNUM];
            SEL_CYLL:    reg_b = param_q[PI_CYLL];
            SEL_CYLH:    reg_b = param_q[PI_CYLH];
            SEL_DEVHEAD: reg_b = param_q[PI_DEVHEAD];
            SEL_STATCMD: reg_b = status_b;
            SEL_ALTCTL:  reg_b = status_b;
            SEL_DEVADDR: reg_b = devaddr_b;
            default:     reg_b = '0;
        endcase
        if (sel == SEL_DATA)
            rd_next = dport_rdata_i;
        else
            rd_next = {{PAD_W{1'b0}}, reg_b};
    end

    // Capture read data at the sampling edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_next;
    end

    assign feature_o  = param_q[PI_FEAT];
    assign sect_cnt_o = param_q[PI_SCNT];
    assign dev_head_o = param_q[PI_DEVHEAD];
    assign lba_o      = {param_q[PI_DEVHEAD][3:0], param_q[PI_CYLH],
                         param_q[PI_CYLL], param_q[PI_SNUM]};
    assign irq_o      = pend & ~nien & dev_match;

    // R10
    nien_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata_i[DC_NIEN]) |=> !irq_o);
    // R3
    dual_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cmd_blk_sel_n && !ctl_blk_sel_n && !srst_o) |=> $stable(param_q));
    // R13
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/pata_tf_regs_tb_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// against rdata_o one half cycle after the sampling edge.
module pata_tf_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_n = 1'b1, ctl_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [15:0] rdata;
    logic [15:0] dport_rdata = '0;
    logic        dport_rd, dport_wr;
    logic        own_dev = 1'b0;
    logic        done = 1'b0, done_err = 1'b0;
    logic [7:0]  done_code = '0;
    logic        cmd_stb, srst, irq;
    logic [7:0]  cmd_code, feature, sect_cnt, dev_head;
    logic [27:0] lba;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    pata_tf_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_blk_sel_n(cmd_n), .ctl_blk_sel_n(ctl_n),
        .reg_addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
        .dport_rdata_i(dport_rdata), .dport_rd_o(dport_rd), .dport_wr_o(dport_wr),
        .own_dev_i(own_dev), .done_i(done), .done_err_i(done_err),
        .done_code_i(done_code), .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code),
        .feature_o(feature), .sect_cnt_o(sect_cnt), .lba_o(lba),
        .dev_head_o(dev_head), .srst_o(srst), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic c0, input logic c1, input logic [2:0] a,
                           input logic [7:0] d);
        @(negedge clk);
        cmd_n = c0; ctl_n = c1; addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0; cmd_n = 1'b1; ctl_n = 1'b1;
    endtask

    task automatic host_rd(input logic c0, input logic c1, input logic [2:0] a,
                           input logic [15:0] exp, input string req);
        @(negedge clk);
        cmd_n = c0; ctl_n = c1; addr = a; rd = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0; cmd_n = 1'b1; ctl_n = 1'b1;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    task automatic finish_cmd(input logic e, input logic [7:0] code);
        @(negedge clk);
        done = 1'b1; done_err = e; done_code = code;
        @(posedge clk); #1;
        done = 1'b0; done_err = 1'b0;
    endtask

    // Monitor: compare each queued read with the registered read data
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(r, {16'h0, rdata}, {16'h0, e});
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R12 reset state
        chk("R12 rdata", rdata, 0);
        chk("R12 irq", irq, 0);
        chk("R12 cmd_stb", cmd_stb, 0);
        chk("R12 lba", lba, 0);
        host_rd(0, 1, 7, 16'h0040, "R12 status");

        // R1 parameter registers
        host_wr(0, 1, 2, 8'h12);
        host_wr(0, 1, 3, 8'h34);
        host_wr(0, 1, 4, 8'h56);
        host_wr(0, 1, 5, 8'h78);
        host_wr(0, 1, 6, 8'hE9);
        host_rd(0, 1, 2, 16'h0012, "R1 scnt");
        host_rd(0, 1, 3, 16'h0034, "R1 snum");
        host_rd(0, 1, 4, 16'h0056, "R1 cyll");
        host_rd(0, 1, 5, 16'h0078, "R1 cylh");
        host_rd(0, 1, 6, 16'h00E9, "R1 devhead");
        chk("R1 lba", lba, 28'h9785634);
        chk("R1 sect_cnt", sect_cnt, 8'h12);

        // R2 split address 1
        host_wr(0, 1, 1, 8'h03);
        chk("R2 feature", feature, 8'h03);
        host_rd(0, 1, 1, 16'h0000, "R2 error");

        // R3 control block and illegal selects
        host_rd(1, 0, 6, 16'h0040, "R3 altstatus");
        host_rd(1, 0, 7, 16'h00DA, "R3 devaddr");
        host_wr(1, 0, 7, 8'hFF);
        host_wr(0, 0, 2, 8'h77);
        host_wr(1, 1, 2, 8'h66);
        host_rd(0, 1, 2, 16'h0012, "R3 scnt unchanged");
        host_rd(0, 0, 2, 16'h0000, "R3 both sel read");
        host_rd(1, 1, 2, 16'h0000, "R3 no sel read");
        chk("R3 irq", irq, 0);

        // R4 data port
        dport_rdata = 16'hBEEF;
        @(negedge clk);
        cmd_n = 0; ctl_n = 1; addr = 0; rd = 1'b1;
        #1 chk("R4 dport_rd", dport_rd, 1);
        @(posedge clk); #1;
        rd = 1'b0; cmd_n = 1'b1;
        exp_q.push_back(16'hBEEF); req_q.push_back("R4 data word");
        @(negedge clk);
        cmd_n = 0; addr = 0; wr = 1'b1;
        #1 chk("R4 dport_wr", dport_wr, 1);
        @(posedge clk); #1;
        wr = 1'b0; cmd_n = 1'b1;

        // R6 unselected device ignores command
        own_dev = 1'b1;
        host_wr(0, 1, 7, 8'h20);
        chk("R6 no stb", cmd_stb, 0);
        host_rd(0, 1, 7, 16'h0040, "R6 status");
        own_dev = 1'b0;

        // R5 command issue
        host_wr(0, 1, 7, 8'h20);
        chk("R5 stb", cmd_stb, 1);
        chk("R5 code", cmd_code, 8'h20);
        @(posedge clk); #1;
        chk("R5 stb one cycle", cmd_stb, 0);
        host_rd(0, 1, 7, 16'h0080, "R5 busy status");

        // R7 writes while busy
        host_wr(0, 1, 2, 8'h99);
        host_rd(0, 1, 2, 16'h0012, "R7 scnt kept");
        host_wr(0, 1, 7, 8'hEC);
        chk("R7 no stb", cmd_stb, 0);
        chk("R7 code kept", cmd_code, 8'h20);
        host_wr(1, 0, 6, 8'h02);

        // R8 / R9 / R10 completion and interrupt
        finish_cmd(0, 8'h55);
        chk("R10 irq masked", irq, 0);
        host_rd(1, 0, 6, 16'h0040, "R8 done status");
        host_wr(1, 0, 6, 8'h00);
        chk("R10 irq unmasked", irq, 1);
        host_rd(1, 0, 6, 16'h0040, "R9 altstatus");
        chk("R9 alt keeps irq", irq, 1);
        host_rd(0, 1, 1, 16'h0000, "R8 no error");
        host_rd(0, 1, 7, 16'h0040, "R9 status");
        chk("R9 status clears irq", irq, 0);

        // R8 error completion, R9 selection gating
        host_wr(0, 1, 7, 8'hC8);
        chk("R8 stb", cmd_stb, 1);
        finish_cmd(1, 8'h04);
        chk("R9 irq", irq, 1);
        own_dev = 1'b1;
        #1 chk("R9 irq deselected", irq, 0);
        own_dev = 1'b0;
        #1 chk("R9 irq reselected", irq, 1);
        host_rd(0, 1, 1, 16'h0004, "R8 error byte");
        host_rd(0, 1, 7, 16'h0041, "R8 err status");
        host_wr(0, 1, 7, 8'hCA);
        host_rd(0, 1, 7, 16'h0080, "R8 err cleared status");
        host_rd(0, 1, 1, 16'h0000, "R8 err cleared byte");
        finish_cmd(0, 8'h00);
        host_rd(0, 1, 7, 16'h0040, "R8 second done");

        // R11 soft reset
        host_wr(1, 0, 6, 8'h04);
        @(posedge clk); #1;
        chk("R11 srst", srst, 1);
        chk("R11 lba", lba, 0);
        chk("R11 scnt", sect_cnt, 0);
        chk("R11 devhead", dev_head, 0);
        host_rd(0, 1, 7, 16'h0080, "R11 busy");
        host_wr(0, 1, 2, 8'h55);
        host_rd(0, 1, 2, 16'h0000, "R11 write ignored");
        host_wr(0, 1, 7, 8'hE5);
        chk("R11 cmd ignored", cmd_stb, 0);
        host_wr(1, 0, 6, 8'h00);
        chk("R11 srst off", srst, 0);
        host_rd(0, 1, 7, 16'h0040, "R11 released");

        // R13 read data holds
        host_wr(0, 1, 2, 8'h21);
        host_rd(0, 1, 2, 16'h0021, "R13 read");
        host_wr(0, 1, 2, 8'h22);
        repeat (3) @(posedge clk);
        #1 chk("R13 hold", rdata, 16'h0021);

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule